// File: doc/BRIEF.md
# Thermal Sensor Channel Controller

This block runs one channel of an on-die temperature monitor. A temperature-dependent ring oscillator arrives as a pulse input. After a two-flop synchroniser and a rising-edge detector, its edges are counted during a measurement window of reference clocks. A new window starts on a fixed schedule, every programmed number of clocks. The count rises with temperature. The count from the most recent window is kept for software to read, together with a valid flag.

When a window closes, the count is compared against three programmable thresholds, giving a thermal level from 0 (cold) to 3. A raised level drives three requests, each gated by its own enable bit: a throttle request, a clock-divide-by-two request and an emergency reset request. The block also raises an interrupt when the level climbs into a level whose interrupt is enabled, or when the counter saturates. A word-addressed register port gives access to configuration, thresholds, status and the count. The interrupt-pending and valid flags are cleared by writing a one to them.

Top module: `thermal_chan_ctrl`

## Requirements
- R1: Registers are addressed by word index. Index 0 is the configuration word. Index 2 holds the low threshold in bits 15:0 and the middle threshold in bits 31:16. Index 3 holds the high threshold in bits 15:0. Index 6 is status and index 7 is the count, in bits 31:16. After reset the configuration reads 0, every threshold reads all ones (of the count width), and status reads 0.
- R2: The configuration word holds the interval M in bits 23:8, the window length N in bits 31:24, and the stop flag in bit 0. Measurement is active only when stop is 0 and both M and N are nonzero. While active, a window opens every M clocks and counts synchronised rising edges for its length.
- R3: The edge count saturates at all ones. It is latched on the last cycle of each window and holds its value between windows.
- R4: Status bit 9 (valid) is set when a window completes. It is cleared while measurement is inactive, or when a one is written to it, unless a window completes in the same cycle.
- R5: When a window closes, the level becomes 3, 2, 1 or 0: the highest of the high, middle and low thresholds that the count meets or exceeds, or 0 if it meets none. Status bits 2:0 report the level, or the value 5 when the count saturated.
- R6: throttle_o follows level ≥ 1 gated by configuration bit 3. clkdiv_o follows level ≥ 2 gated by bit 1. therm_rst_o follows level 3 gated by bit 2.
- R7: The pending bit (status bit 8, also driven on irq_o) is set in three cases. It is set when a window raises the level into 2 with bit 5 set, or into 3 with bit 6 set. It is also set when a window saturates with bit 4 set. Writing a one to bit 8 clears it, but a set in the same cycle takes priority.
- R8: A window that leaves the level unchanged or lowers it sets no pending bit, unless the count saturated.
- R9: When N ≥ M, the window is clipped to M clocks, so it always closes before the next one opens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| osc_i | input | 1 | Oscillator pulse input, asynchronous |
| reg_we_i | input | 1 | Register write strobe |
| reg_idx_i | input | 3 | Register word index |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_idx_i, combinational |
| throttle_o | output | 1 | Passive throttle request |
| clkdiv_o | output | 1 | Clock divide-by-two request |
| therm_rst_o | output | 1 | Emergency reset request |
| irq_o | output | 1 | Interrupt pending |

## Verification
Saturation is the hardest state to reach from the ports. At the default width, a full 16-bit count needs more edges than even the longest window can hold, because a rising edge needs at least two clocks. The bench therefore builds the block with a 6-bit count. It then drives the oscillator at its fastest toggle rate over a long window, so that the counter saturates, the status reads 5 and the overflow interrupt fires. Clipping and rises, repeats and falls of the level are reached by changing the oscillator rate between windows while the schedule keeps running.

// File: rtl/thermal_pkg.sv
package thermal_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned IDX_W  = 3;
  localparam int unsigned M_W    = 16;
  localparam int unsigned N_W    = 8;
  localparam int unsigned M_LSB  = 8;
  localparam int unsigned N_LSB  = 24;

  localparam logic [IDX_W-1:0] IDX_CFG  = 3'd0;
  localparam logic [IDX_W-1:0] IDX_THA  = 3'd2;
  localparam logic [IDX_W-1:0] IDX_THB  = 3'd3;
  localparam logic [IDX_W-1:0] IDX_STAT = 3'd6;
  localparam logic [IDX_W-1:0] IDX_CNT  = 3'd7;

  localparam int unsigned B_STOP   = 0;
  localparam int unsigned B_DIV    = 1;
  localparam int unsigned B_RST    = 2;
  localparam int unsigned B_THR    = 3;
  localparam int unsigned B_IE_OVF = 4;
  localparam int unsigned B_IE_DIV = 5;
  localparam int unsigned B_IE_RST = 6;
  localparam logic [DATA_W-1:0] CFG_MASK = 32'hFFFF_FF7F;

  localparam int unsigned B_PEND  = 8;
  localparam int unsigned B_VALID = 9;
  localparam logic [2:0] ST_OVF = 3'd5;

  typedef enum logic [1:0] {
    LVL_COLD = 2'd0,
    LVL_THR  = 2'd1,
    LVL_DIV  = 2'd2,
    LVL_RST  = 2'd3
  } level_e;
endpackage

// File: rtl/tsc_sync.sv
module tsc_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic osc_i,
  output logic rise_o
);
  logic [2:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[1:0], osc_i};
  end

  assign rise_o = sh_q[1] & ~sh_q[2];
endmodule

// File: rtl/tsc_meas.sv
module tsc_meas
  import thermal_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rise_i,
  input  logic             stop_i,
  input  logic [M_W-1:0]   m_i,
  input  logic [N_W-1:0]   n_i,
  input  logic             clr_valid_i,
  output logic             done_o,
  output logic [CNT_W-1:0] result_o,
  output logic [CNT_W-1:0] count_o,
  output logic             valid_o
);
  logic             active;
  logic [M_W-1:0]   n_ext, win_len, per_q;
  logic [CNT_W-1:0] cnt_q, count_q, base, inc;
  logic             in_win, last, valid_q;

  assign active  = !stop_i && (m_i != '0) && (n_i != '0);
  assign n_ext   = M_W'(n_i);
  assign win_len = (n_ext < m_i) ? n_ext : m_i;  // clip window to interval
  assign in_win  = per_q < win_len;
  assign last    = active && (per_q == win_len - 1'b1);
  assign base    = (per_q == '0) ? '0 : cnt_q;
  assign inc     = (rise_i && !(&base)) ? base + 1'b1 : base;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_q   <= '0;
      cnt_q   <= '0;
      count_q <= '0;
      valid_q <= 1'b0;
    end else begin
      if (!active)                   per_q <= '0;
      else if (per_q >= m_i - 1'b1)  per_q <= '0;
      else                           per_q <= per_q + 1'b1;
      if (active && in_win) cnt_q <= inc;
      if (last) count_q <= inc;
      if (!active)          valid_q <= 1'b0;
      else if (last)        valid_q <= 1'b1;
      else if (clr_valid_i) valid_q <= 1'b0;
    end
  end

  assign done_o   = last;
  assign result_o = inc;
  assign count_o  = count_q;
  assign valid_o  = valid_q;

  p_count_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !last |=> $stable(count_q));
  p_phase_in_interval_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && $stable(m_i)) |-> (per_q < m_i));
  p_valid_needs_active_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active |=> !valid_q);
  p_window_closes_early_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last |-> (per_q < m_i));
endmodule

// File: rtl/tsc_level.sv
module tsc_level
  import thermal_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             done_i,
  input  logic [CNT_W-1:0] result_i,
  input  logic [CNT_W-1:0] th_lo_i,
  input  logic [CNT_W-1:0] th_mid_i,
  input  logic [CNT_W-1:0] th_hi_i,
  input  logic             en_thr_i,
  input  logic             en_div_i,
  input  logic             en_rst_i,
  input  logic             ie_ovf_i,
  input  logic             ie_div_i,
  input  logic             ie_rst_i,
  input  logic             clr_pend_i,
  output logic [2:0]       state_o,
  output logic             pend_o,
  output logic             throttle_o,
  output logic             clkdiv_o,
  output logic             therm_rst_o
);
  level_e lvl_q, new_lvl;
  logic   ovf_q, sat_now, lvl_up, set_pend, pend_q;

  always_comb begin
    if      (result_i >= th_hi_i)  new_lvl = LVL_RST;
    else if (result_i >= th_mid_i) new_lvl = LVL_DIV;
    else if (result_i >= th_lo_i)  new_lvl = LVL_THR;
    else                           new_lvl = LVL_COLD;
  end

  assign sat_now  = &result_i;
  assign lvl_up   = new_lvl > lvl_q;
  assign set_pend = done_i && ((lvl_up && new_lvl == LVL_DIV && ie_div_i) ||
                               (lvl_up && new_lvl == LVL_RST && ie_rst_i) ||
                               (sat_now && ie_ovf_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q  <= LVL_COLD;
      ovf_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (done_i) begin
        lvl_q <= new_lvl;
        ovf_q <= sat_now;
      end
      if (set_pend)        pend_q <= 1'b1;
      else if (clr_pend_i) pend_q <= 1'b0;
    end
  end

  assign state_o     = ovf_q ? ST_OVF : {1'b0, lvl_q};
  assign pend_o      = pend_q;
  assign throttle_o  = en_thr_i && (lvl_q != LVL_COLD);
  assign clkdiv_o    = en_div_i && (lvl_q >= LVL_DIV);
  assign therm_rst_o = en_rst_i && (lvl_q == LVL_RST);

  p_ovf_is_top_level_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_q |-> (lvl_q == LVL_RST));
  p_pend_from_window_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pend_q) |-> $past(done_i));
  p_no_irq_on_fall_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && new_lvl <= lvl_q && !sat_now) |=> !$rose(pend_q));
  p_level_moves_on_window_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_i |=> $stable(lvl_q));
endmodule

// File: rtl/thermal_chan_ctrl.sv
module thermal_chan_ctrl
  import thermal_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              osc_i,
  input  logic              reg_we_i,
  input  logic [IDX_W-1:0]  reg_idx_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              throttle_o,
  output logic              clkdiv_o,
  output logic              therm_rst_o,
  output logic              irq_o
);
  localparam int unsigned HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] cfg_q;
  logic [CNT_W-1:0]  th_lo_q, th_mid_q, th_hi_q, result, count;
  logic [HALF_W-1:0] th_lo_w, th_mid_w, th_hi_w, count_w;
  logic              rise, done, valid, pend, wr_stat;
  logic [2:0]        state;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q    <= '0;
      th_lo_q  <= '1;
      th_mid_q <= '1;
      th_hi_q  <= '1;
    end else if (reg_we_i) begin
      case (reg_idx_i)
        IDX_CFG: cfg_q <= reg_wdata_i & CFG_MASK;
        IDX_THA: begin
          th_lo_q  <= reg_wdata_i[CNT_W-1:0];
          th_mid_q <= reg_wdata_i[HALF_W +: CNT_W];
        end
        IDX_THB: th_hi_q <= reg_wdata_i[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  assign wr_stat = reg_we_i && (reg_idx_i == IDX_STAT);

  tsc_sync u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .osc_i (osc_i),
    .rise_o(rise)
  );

  tsc_meas #(.CNT_W(CNT_W)) u_meas (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rise_i     (rise),
    .stop_i     (cfg_q[B_STOP]),
    .m_i        (cfg_q[M_LSB +: M_W]),
    .n_i        (cfg_q[N_LSB +: N_W]),
    .clr_valid_i(wr_stat && reg_wdata_i[B_VALID]),
    .done_o     (done),
    .result_o   (result),
    .count_o    (count),
    .valid_o    (valid)
  );

  tsc_level #(.CNT_W(CNT_W)) u_level (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .done_i     (done),
    .result_i   (result),
    .th_lo_i    (th_lo_q),
    .th_mid_i   (th_mid_q),
    .th_hi_i    (th_hi_q),
    .en_thr_i   (cfg_q[B_THR]),
    .en_div_i   (cfg_q[B_DIV]),
    .en_rst_i   (cfg_q[B_RST]),
    .ie_ovf_i   (cfg_q[B_IE_OVF]),
    .ie_div_i   (cfg_q[B_IE_DIV]),
    .ie_rst_i   (cfg_q[B_IE_RST]),
    .clr_pend_i (wr_stat && reg_wdata_i[B_PEND]),
    .state_o    (state),
    .pend_o     (pend),
    .throttle_o (throttle_o),
    .clkdiv_o   (clkdiv_o),
    .therm_rst_o(therm_rst_o)
  );

  always_comb begin
    th_lo_w  = '0; th_lo_w[CNT_W-1:0]  = th_lo_q;
    th_mid_w = '0; th_mid_w[CNT_W-1:0] = th_mid_q;
    th_hi_w  = '0; th_hi_w[CNT_W-1:0]  = th_hi_q;
    count_w  = '0; count_w[CNT_W-1:0]  = count;
  end

  always_comb begin
    reg_rdata_o = '0;
    case (reg_idx_i)
      IDX_CFG:  reg_rdata_o = cfg_q;
      IDX_THA:  reg_rdata_o = {th_mid_w, th_lo_w};
      IDX_THB:  reg_rdata_o = {{HALF_W{1'b0}}, th_hi_w};
      IDX_STAT: begin
        reg_rdata_o[2:0]     = state;
        reg_rdata_o[B_PEND]  = pend;
        reg_rdata_o[B_VALID] = valid;
      end
      IDX_CNT:  reg_rdata_o = {count_w, {HALF_W{1'b0}}};
      default:  reg_rdata_o = '0;
    endcase
  end

  assign irq_o = pend;

  p_cfg_reset_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!rst_ni) |-> (cfg_q == '0));
  p_w1c_pend_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stat && reg_wdata_i[B_PEND] && !done) |=> !pend);
endmodule

// File: tb/sim_thermal_chan_ctrl.sv
module sim_thermal_chan_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int CW   = 6;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0, rst_n = 1'b0, osc = 1'b0, we = 1'b0;
  logic [2:0]  idx = 3'd0;
  logic [31:0] wdata = '0, rdata;
  logic throttle, clkdiv, trst, irq;

  int n_checks = 0, n_fail = 0, osc_half = 0, osc_ctr = 0;
  bit running = 1'b0;

  thermal_chan_ctrl #(.CNT_W(CW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .osc_i(osc), .reg_we_i(we), .reg_idx_i(idx),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .throttle_o(throttle),
    .clkdiv_o(clkdiv), .therm_rst_o(trst), .irq_o(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model
  logic [31:0] m_cfg = '0;
  int m_th1 = CMAX, m_th2 = CMAX, m_th3 = CMAX;
  int m_per = 0, m_cnt = 0, m_count = 0, m_lvl = 0;
  bit m_s1 = 0, m_s2 = 0, m_s3 = 0, m_valid = 0, m_ovf = 0, m_pend = 0;

  task automatic m_step();
    bit edge_now = m_s2 && !m_s3;
    int mm = int'(m_cfg[23:8]);
    int nn = int'(m_cfg[31:24]);
    bit act = !m_cfg[0] && mm != 0 && nn != 0;
    int w = (nn < mm) ? nn : mm;
    bit setv = 0, setp = 0;
    if (act) begin
      int base = (m_per == 0) ? 0 : m_cnt;
      int inc = (edge_now && base < CMAX) ? base + 1 : base;
      if (m_per < w) m_cnt = inc;
      if (m_per == w - 1) begin
        int nl = (inc >= m_th3) ? 3 : (inc >= m_th2) ? 2 : (inc >= m_th1) ? 1 : 0;
        m_count = inc; m_valid = 1; setv = 1;
        setp = (nl > m_lvl && ((nl == 2 && m_cfg[5]) || (nl == 3 && m_cfg[6]))) ||
               (inc == CMAX && m_cfg[4]);
        if (setp) m_pend = 1;
        m_lvl = nl; m_ovf = (inc == CMAX);
      end
      m_per = (m_per >= mm - 1) ? 0 : m_per + 1;
    end else begin
      m_per = 0; m_valid = 0;
    end
    if (we) begin
      case (idx)
        3'd0: m_cfg = wdata & 32'hFFFF_FF7F;
        3'd2: begin m_th1 = int'(wdata[CW-1:0]); m_th2 = int'(wdata[16 +: CW]); end
        3'd3: m_th3 = int'(wdata[CW-1:0]);
        3'd6: begin
          if (wdata[9] && !setv) m_valid = 0;
          if (wdata[8] && !setp) m_pend = 0;
        end
        default: ;
      endcase
    end
    m_s3 = m_s2; m_s2 = m_s1; m_s1 = osc;
  endtask

  always @(posedge clk) if (rst_n) m_step();

  function automatic logic [31:0] m_read(logic [2:0] i);
    logic [31:0] r = '0;
    case (i)
      3'd0: r = m_cfg;
      3'd2: r = (32'(m_th2) << 16) | 32'(m_th1);
      3'd3: r = 32'(m_th3);
      3'd6: begin r[2:0] = m_ovf ? 3'd5 : 3'(m_lvl); r[8] = m_pend; r[9] = m_valid; end
      3'd7: r = 32'(m_count) << 16;
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s t=%0t actual=%h expected=%h", tag, $time, act, exp);
    end
  endtask

  // per-cycle comparison, away from the active edge
  always @(negedge clk) if (running) begin
    chk("R6 throttle", 32'(throttle), 32'(m_cfg[3] && m_lvl >= 1));
    chk("R6 clkdiv",   32'(clkdiv),   32'(m_cfg[1] && m_lvl >= 2));
    chk("R6 therm_rst", 32'(trst),    32'(m_cfg[2] && m_lvl == 3));
    chk("R7 irq",      32'(irq),      32'(m_pend));
    case (idx)
      3'd6:    chk("R4 status", rdata, m_read(idx));
      3'd7:    chk("R3 count",  rdata, m_read(idx));
      default: chk("R1 reg",    rdata, m_read(idx));
    endcase
  end

  // oscillator stimulus
  always begin
    @(posedge clk); #1;
    if (osc_half == 0) begin osc = 1'b0; osc_ctr = 0; end
    else if (++osc_ctr >= osc_half) begin osc = ~osc; osc_ctr = 0; end
  end

  task automatic wr(logic [2:0] i, logic [31:0] d);
    @(posedge clk); #1;
    we = 1'b1; idx = i; wdata = d;
    @(posedge clk); #1;
    we = 1'b0; wdata = '0;
  endtask

  task automatic look(logic [2:0] i, string tag);
    @(posedge clk); #1;
    idx = i;
    @(negedge clk);
    chk(tag, rdata, m_read(i));
  endtask

  task automatic run(int n);
    repeat (n) @(posedge clk);
  endtask

  function automatic logic [31:0] cfgw(int n, int m, logic [7:0] fl);
    return (32'(n) << 24) | (32'(m) << 8) | 32'(fl);
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    run(4); #1; rst_n = 1'b1; running = 1'b1;
    // R1 reset values
    look(3'd0, "R1 cfg reset");   chk("R1 cfg const", rdata, 32'h0);
    look(3'd2, "R1 tha reset");   chk("R1 tha const", rdata, 32'h003F_003F);
    look(3'd3, "R1 thb reset");   chk("R1 thb const", rdata, 32'h0000_003F);
    look(3'd6, "R1 stat reset");  chk("R1 stat const", rdata, 32'h0);
    // R2/R4: M zero keeps channel idle
    osc_half = 2;
    wr(3'd0, cfgw(10, 0, 8'h7E)); run(80);
    look(3'd6, "R4 idle"); chk("R2 idle no valid", rdata & 32'h200, 32'h0);
    // thresholds and normal windows
    wr(3'd2, (32'd10 << 16) | 32'd5);
    wr(3'd3, 32'd14);
    osc_half = 4;
    wr(3'd0, cfgw(30, 40, 8'h7E)); run(200);
    look(3'd6, "R4 valid after window"); look(3'd7, "R3 slow count");
    osc_half = 2; run(200);
    look(3'd6, "R5 level one"); chk("R6 throttle on", 32'(throttle), 32'd1);
    osc_half = 1; run(120);
    look(3'd6, "R5 level three"); chk("R7 irq on rise", 32'(irq), 32'd1);
    // R7 W1C
    wr(3'd6, 32'h300); look(3'd6, "R7 w1c");
    run(100); look(3'd6, "R8 same level"); chk("R8 no irq repeat", 32'(irq), 32'd0);
    osc_half = 2; run(120); look(3'd6, "R8 fall no irq");
    // gating: reset request and its irq disabled
    wr(3'd0, cfgw(30, 40, 8'h2A)); osc_half = 1; run(160);
    look(3'd6, "R7 gated irq"); chk("R6 trst gated", 32'(trst), 32'd0);
    // R9 clipping
    wr(3'd0, cfgw(200, 12, 8'h7E)); run(100);
    look(3'd7, "R9 clipped count"); look(3'd6, "R9 clipped status");
    // saturation
    wr(3'd6, 32'h300);
    wr(3'd0, cfgw(150, 200, 8'h7E)); run(500);
    look(3'd6, "R5 overflow state"); chk("R5 state five", 32'(rdata[2:0]), 32'd5);
    look(3'd7, "R3 saturated"); chk("R3 sat value", rdata, 32'(CMAX) << 16);
    chk("R7 overflow irq", 32'(irq), 32'd1);
    // R2 stop
    wr(3'd0, cfgw(150, 200, 8'h7F)); run(30);
    look(3'd6, "R2 stopped"); chk("R4 stop clears valid", rdata & 32'h200, 32'h0);
    running = 1'b0;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule